// File: doc/BRIEF.md
# Quadrature Test Signal Generator

This block synthesises a two-phase quadrature waveform so that a quadrature decoder can be exercised without a moving encoder. When test routing is selected, the generated phases replace the external phase inputs on the way to the decoder. When it is not selected, the external inputs pass straight through.

A separate run enable starts the generator. It then emits a programmed number of quadrature steps, one step every programmed number of clocks, in the chosen rotation direction. After the last step it raises a done indication and holds the final phase state. Clearing either enable returns the generator to its idle state, so writing all control fields to zero disables it completely.

Top module: `qtest_gen`

## Requirements
- R1: After reset, gen_a, gen_b and done are 0.
- R2: With tst_en at 0, dec_a/dec_b equal ext_a/ext_b. With tst_en at 1, dec_a/dec_b equal gen_a/gen_b.
- R3: The generator is active only while tst_en and gen_en are both 1. While either is 0, on the next clock edge gen_a, gen_b and done are 0 and the step tally restarts from zero.
- R4: Let P be period, or 1 when period is 0. Once the generator is active, the k-th step appears on clock edge k*P, counting the first active edge as edge 1.
- R5: With dir_neg at 0, {gen_b,gen_a} steps 00, 01, 11, 10, 00 (A leads B). With dir_neg at 1, it steps through the same states in the reverse order (B leads A).
- R6: done rises on edge step_cnt*P+1 after activation. When step_cnt is 0, done rises on edge 1 and no step occurs.
- R7: Once done is 1 and the generator stays active, gen_a and gen_b hold their values and done stays 1.
- R8: While the generator stays active, gen_a and gen_b never both change on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tst_en | input | 1 | Routes generated phases to the decoder and enables the generator |
| gen_en | input | 1 | Starts counting out the programmed steps |
| period | input | PER_W | Clocks per quadrature step (0 is treated as 1) |
| step_cnt | input | CNT_W | Number of steps to emit |
| dir_neg | input | 1 | 0: A leads B, 1: B leads A |
| ext_a | input | 1 | External phase A |
| ext_b | input | 1 | External phase B |
| gen_a | output | 1 | Generated phase A |
| gen_b | output | 1 | Generated phase B |
| dec_a | output | 1 | Phase A presented to the decoder |
| dec_b | output | 1 | Phase B presented to the decoder |
| done | output | 1 | All programmed steps emitted |

## Verification
The generated phases and done are registered, so a change to the enables or parameters shows one edge later. Step k is due on edge k*P and done on edge step_cnt*P+1. The decoder mux is combinational and is checked within the same cycle. The bench applies every stimulus at a falling edge and samples after each of the following falling edges, comparing against a step count min(n/P, step_cnt) that it computes itself for edge n.

// File: rtl/qtg_pkg.sv
package qtg_pkg;
    typedef logic [1:0] qidx_t;

    // Position index 0..3 to phases: {B,A} = 00,01,11,10
    function automatic logic [1:0] idx_to_ba(qidx_t idx);
        return {idx[1], idx[1] ^ idx[0]};
    endfunction
endpackage

// File: rtl/qtg_tick.sv
module qtg_tick #(
    parameter int PER_W = 8
) (
    input  logic [PER_W-1:0] period,
    input  logic [PER_W-1:0] timer_q,
    output logic             tick,
    output logic [PER_W-1:0] timer_d
);
    logic [PER_W-1:0] last;

    always_comb begin
        last    = (period == '0) ? '0 : period - 1'b1;
        tick    = (timer_q >= last);
        timer_d = tick ? '0 : timer_q + 1'b1;
    end
endmodule

// File: rtl/qtg_phase.sv
module qtg_phase
    import qtg_pkg::*;
(
    input  qidx_t idx,
    output logic  pa,
    output logic  pb
);
    logic [1:0] ba;

    always_comb begin
        ba = idx_to_ba(idx);
        pa = ba[0];
        pb = ba[1];
    end
endmodule

// File: rtl/qtest_gen.sv
module qtest_gen
    import qtg_pkg::*;
#(
    parameter int PER_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tst_en,
    input  logic             gen_en,
    input  logic [PER_W-1:0] period,
    input  logic [CNT_W-1:0] step_cnt,
    input  logic             dir_neg,
    input  logic             ext_a,
    input  logic             ext_b,
    output logic             gen_a,
    output logic             gen_b,
    output logic             dec_a,
    output logic             dec_b,
    output logic             done
);
    typedef struct packed {
        logic [PER_W-1:0] timer;
        logic [CNT_W-1:0] steps;
        qidx_t            idx;
        logic             done;
    } state_t;

    state_t st_q, st_d;
    logic             active;
    logic             tick;
    logic [PER_W-1:0] timer_nxt;

    qtg_tick #(.PER_W(PER_W)) u_tick (
        .period  (period),
        .timer_q (st_q.timer),
        .tick    (tick),
        .timer_d (timer_nxt)
    );

    always_comb begin
        active = tst_en & gen_en;
        st_d   = st_q;
        if (!active) begin
            st_d = '0;
        end else if (st_q.steps >= step_cnt) begin
            st_d.done = 1'b1;
        end else begin
            st_d.timer = timer_nxt;
            if (tick) begin
                st_d.steps = st_q.steps + 1'b1;
                st_d.idx   = dir_neg ? st_q.idx - 2'd1 : st_q.idx + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    qtg_phase u_phase (
        .idx (st_q.idx),
        .pa  (gen_a),
        .pb  (gen_b)
    );

    assign done  = st_q.done;
    assign dec_a = tst_en ? gen_a : ext_a;
    assign dec_b = tst_en ? gen_b : ext_b;
endmodule

// File: rtl/qtest_gen_chk.sv
module qtest_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic tst_en,
    input logic gen_en,
    input logic gen_a,
    input logic gen_b,
    input logic done
);
    logic act;
    assign act = tst_en & gen_en;

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(act) |-> (!gen_a && !gen_b && !done)); // R3

    AST_ONE_BIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act)) |-> ($countones({gen_a, gen_b} ^ $past({gen_a, gen_b})) <= 1)); // R8

    AST_DONE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(act) && $past(done) && act) |=> $stable({gen_a, gen_b})); // R7

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(done) && $past(act)) |-> done); // R7
endmodule

bind qtest_gen qtest_gen_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tst_en (tst_en),
    .gen_en (gen_en),
    .gen_a  (gen_a),
    .gen_b  (gen_b),
    .done   (done)
);

// File: tb/sim_qtest_gen.sv
`timescale 1ns/1ps
module sim_qtest_gen;
    localparam int PER_W = 8;
    localparam int CNT_W = 8;
    localparam int NV = 7;
    // {period, step_cnt, dir_neg}
    localparam logic [16:0] VEC [NV] = '{
        {8'd0, 8'd3, 1'b0},
        {8'd1, 8'd5, 1'b1},
        {8'd3, 8'd4, 1'b0},
        {8'd2, 8'd0, 1'b1},
        {8'd4, 8'd6, 1'b1},
        {8'd5, 8'd2, 1'b0},
        {8'd0, 8'd9, 1'b1}
    };

    logic clk = 0, rst_n = 0;
    logic tst_en = 0, gen_en = 0, dir_neg = 0, ext_a = 0, ext_b = 0;
    logic [PER_W-1:0] period = '0;
    logic [CNT_W-1:0] step_cnt = '0;
    logic gen_a, gen_b, dec_a, dec_b, done;
    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    qtest_gen #(.PER_W(PER_W), .CNT_W(CNT_W)) u0 (.*);

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ba_of(input int steps, input logic neg);
        int i;
        i = neg ? (4 - (steps % 4)) % 4 : steps % 4;
        return (i == 0) ? 2'b00 : (i == 1) ? 2'b01 : (i == 2) ? 2'b11 : 2'b10;
    endfunction

    initial begin
        #20000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [1:0] prev;
        @(negedge clk); @(negedge clk);
        chk("R1 reset", {1'b0, done, gen_b, gen_a}, 4'h0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 after release", {1'b0, done, gen_b, gen_a}, 4'h0);

        // R2: pass-through when test routing is off; generator idle (R3)
        ext_a = 1; ext_b = 0; gen_en = 1; period = 0; step_cnt = 5;
        #1 chk("R2 ext route", {2'b0, dec_b, dec_a}, 4'h1);
        @(negedge clk); @(negedge clk);
        chk("R3 idle without tst_en", {1'b0, done, gen_b, gen_a}, 4'h0);
        ext_a = 0; ext_b = 1;
        #1 chk("R2 ext route 2", {2'b0, dec_b, dec_a}, 4'h2);
        gen_en = 0;

        // vector table: R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            int p, c, last;
            p = (VEC[v][16:9] == 0) ? 1 : int'(VEC[v][16:9]);
            c = int'(VEC[v][8:1]);
            tst_en = 1; gen_en = 0;
            period = VEC[v][16:9]; step_cnt = VEC[v][8:1]; dir_neg = VEC[v][0];
            @(negedge clk);
            chk("R3 cleared", {1'b0, done, gen_b, gen_a}, 4'h0);
            gen_en = 1;
            prev = 2'b00;
            last = c * p + 3;
            for (int n = 1; n <= last; n++) begin
                int s;
                @(negedge clk);
                s = n / p; if (s > c) s = c;
                chk($sformatf("R4 R5 v%0d edge%0d", v, n), {2'b0, gen_b, gen_a}, {2'b0, ba_of(s, dir_neg)});
                chk($sformatf("R6 R7 done v%0d edge%0d", v, n), {3'b0, done}, {3'b0, (n >= c * p + 1)});
                chk("R8 one bit", 4'(($countones({gen_b, gen_a} ^ prev) <= 1)), 4'h1);
                chk("R2 test route", {2'b0, dec_b, dec_a}, {2'b0, gen_b, gen_a});
                prev = {gen_b, gen_a};
            end
        end

        // R3: dropping gen_en mid-run clears everything
        gen_en = 0; @(negedge clk);
        period = 3; step_cnt = 8; dir_neg = 0; gen_en = 1;
        repeat (7) @(negedge clk);
        chk("R4 mid-run two steps", {2'b0, gen_b, gen_a}, 4'h3);
        gen_en = 0;
        @(negedge clk);
        chk("R3 stop clears", {1'b0, done, gen_b, gen_a}, 4'h0);
        // restart counts from zero again
        gen_en = 1;
        repeat (3) @(negedge clk);
        chk("R3 restart from zero", {2'b0, gen_b, gen_a}, 4'h1);
        // all-zero control disables
        tst_en = 0; gen_en = 0; period = 0; step_cnt = 0; ext_a = 1; ext_b = 1;
        @(negedge clk);
        chk("R3 all zero", {1'b0, done, gen_b, gen_a}, 4'h0);
        chk("R2 back to ext", {2'b0, dec_b, dec_a}, 4'h3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule